// File: doc/BRIEF.md
# Extender-Based Ripple ALU

This block is a purely combinational arithmetic and logic unit for two operands of a parameterised width (4 bits by default). A 3-bit operation code selects one of eight operations. The top code bit picks the class: logical when 0, arithmetic when 1. The two lower bits pick one of four operations inside that class.

Every bit position has three parts. A logic extender forms the first adder input. An arithmetic extender forms the second adder input. A full adder combines the two. One carry extender sets the carry into the lowest position.

Logical results are formed entirely in the logic extenders. They then travel through the ripple chain with a zero second input and a zero carry-in, so they reach the result unchanged. The arithmetic operations all become additions: the second input is rewritten as B, the inverse of B, all zeros or all ones, and the carry-in is set to match. Besides the result, the block reports an unsigned overflow flag and a signed overflow flag.

Top module: `ext_alu`

## Requirements
- R1: With op_i=000 the result is A, with 001 it is A AND B, with 010 it is A OR B, and with 011 it is the bitwise inverse of A.
- R2: With op_i=100 the result is (A+B) mod 2^W, and with 101 it is (A-B) mod 2^W.
- R3: With op_i=110 the result is (A+1) mod 2^W, and with 111 it is (A-1) mod 2^W.
- R4: uovf_o is the carry out of the most significant position. For add it is 1 when A+B >= 2^W. For subtract it is 1 when A >= B (no borrow). For increment it is 1 when A is all ones. For decrement it is 1 when A is not zero.
- R5: For op_i[2]=1, sovf_o is 1 exactly when the two's-complement result of the operation, taken over signed operands, lies outside the range -2^(W-1) to 2^(W-1)-1.
- R6: For op_i[2]=0, both uovf_o and sovf_o are 0.
- R7: For op_i equal to 000, 011, 110 or 111, the value of b_i has no effect on any output.
- R8: With W=4, A=5 and B=3, op_i codes 000 through 111 give the results 5, 1, 7, 10, 8, 2, 6 and 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code; bit 2 selects the class |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| f_o | output | WIDTH | Result |
| uovf_o | output | 1 | Carry out of the top position (unsigned overflow) |
| sovf_o | output | 1 | Carry into the top position XOR carry out of it (signed overflow) |

## Verification
There is no state, so any fault shows at the ports in the same evaluation as the input that exposes it. A wrong extender term corrupts f_o only for the codes and bit values that reach that term. For this reason the sweep drives every code with every operand pair. A wrong carry-in shifts each result of one operation by exactly one. A carry-chain fault shows as a wrong upper bit or a wrong flag, and only when a carry actually ripples into the faulty position.

// File: rtl/ext_alu_pkg.sv
package ext_alu_pkg;
  typedef enum logic [2:0] {
    OP_PASS = 3'b000,
    OP_AND  = 3'b001,
    OP_OR   = 3'b010,
    OP_NOT  = 3'b011,
    OP_ADD  = 3'b100,
    OP_SUB  = 3'b101,
    OP_INC  = 3'b110,
    OP_DEC  = 3'b111
  } alu_op_e;
endpackage

// File: rtl/alu_logic_ext.sv
module alu_logic_ext
  import ext_alu_pkg::*;
(
  input  alu_op_e op_i,
  input  logic    a_i,
  input  logic    b_i,
  output logic    x_o
);
  always_comb begin
    case (op_i)
      OP_PASS: x_o = a_i;
      OP_AND:  x_o = a_i & b_i;
      OP_OR:   x_o = a_i | b_i;
      OP_NOT:  x_o = ~a_i;
      default: x_o = a_i;  // arithmetic class: operand unchanged
    endcase
  end
endmodule

// File: rtl/alu_arith_ext.sv
module alu_arith_ext
  import ext_alu_pkg::*;
(
  input  alu_op_e op_i,
  input  logic    b_i,
  output logic    y_o
);
  always_comb begin
    case (op_i)
      OP_ADD:  y_o = b_i;
      OP_SUB:  y_o = ~b_i;
      OP_INC:  y_o = 1'b0;
      OP_DEC:  y_o = 1'b1;
      default: y_o = 1'b0;  // logical class: adder adds zero
    endcase
  end
endmodule

// File: rtl/alu_carry_ext.sv
module alu_carry_ext
  import ext_alu_pkg::*;
(
  input  alu_op_e op_i,
  output logic    c0_o
);
  logic [2:0] sel;
  assign sel  = op_i;
  assign c0_o = sel[2] & (sel[1] ^ sel[0]);
endmodule

// File: rtl/alu_full_adder.sv
module alu_full_adder (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic p;
  assign p   = x_i ^ y_i;
  assign s_o = p ^ c_i;
  assign c_o = (x_i & y_i) | (p & c_i);
endmodule

// File: rtl/ext_alu.sv
module ext_alu
  import ext_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] f_o,
  output logic             uovf_o,
  output logic             sovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  alu_op_e          op;
  logic [WIDTH:0]   c;
  logic [WIDTH-1:0] x;
  logic [WIDTH-1:0] y;

  assign op = alu_op_e'(op_i);

  alu_carry_ext i_carry_ext (
    .op_i (op),
    .c0_o (c[0])
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_logic_ext i_logic_ext (
      .op_i (op),
      .a_i  (a_i[i]),
      .b_i  (b_i[i]),
      .x_o  (x[i])
    );
    alu_arith_ext i_arith_ext (
      .op_i (op),
      .b_i  (b_i[i]),
      .y_o  (y[i])
    );
    alu_full_adder i_fa (
      .x_i (x[i]),
      .y_i (y[i]),
      .c_i (c[i]),
      .s_o (f_o[i]),
      .c_o (c[i+1])
    );
  end

  assign uovf_o = c[WIDTH];
  assign sovf_o = c[WIDTH] ^ c[MSB];

  always_comb begin
    if (!op_i[2]) begin
      // R1: logical class leaves the adder idle
      p_logic_adder_idle_r1: assert (y == '0 && !c[0] && f_o == x)
        else $error("logical op disturbed adder");
      p_logic_flags_clear_r6: assert (!uovf_o && !sovf_o)
        else $error("flag set on logical op");
    end else begin
      p_arith_passes_a_r2: assert (x == a_i)
        else $error("first operand altered on arithmetic op");
    end
    if (op_i == 3'b110) begin
      p_inc_feed_r3: assert (y == '0 && c[0])
        else $error("increment feed wrong");
    end
    if (op_i == 3'b111) begin
      p_dec_feed_r3: assert (y == '1 && !c[0])
        else $error("decrement feed wrong");
    end
  end
endmodule

// File: tb/test_ext_alu.sv
module test_ext_alu;
  localparam int unsigned WIDTH      = 4;
  localparam int          CLK_PERIOD = 10;
  localparam int          NVAL       = 1 << WIDTH;
  localparam int          HALF       = NVAL / 2;

  logic             clk = 1'b0;
  logic [2:0]       op;
  logic [WIDTH-1:0] a;
  logic [WIDTH-1:0] b;
  logic [WIDTH-1:0] f;
  logic             uovf;
  logic             sovf;
  int               n_checks = 0;
  int               n_fail   = 0;
  bit               done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_alu #(.WIDTH(WIDTH)) i_ext_alu (
    .op_i   (op),
    .a_i    (a),
    .b_i    (b),
    .f_o    (f),
    .uovf_o (uovf),
    .sovf_o (sovf)
  );

  function automatic int sval(int v);
    return (v >= HALF) ? v - NVAL : v;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%0d b=%0d actual=%0d expected=%0d", req, op, a, b, act, exp);
    end
  endtask

  task automatic apply(int o, int av, int bv);
    @(negedge clk);
    op = o[2:0];
    a  = av[WIDTH-1:0];
    b  = bv[WIDTH-1:0];
    @(posedge clk);
    #1;
  endtask

  initial begin
    op = '0; a = '0; b = '0;
    // initial state: pass of zero gives zero, flags clear
    apply(0, 0, 0);
    check("R1", int'(f), 0);
    check("R6", int'(uovf), 0);

    // R8: reference vector with A=5, B=3
    begin
      int ref8 [8] = '{5, 1, 7, 10, 8, 2, 6, 4};
      for (int o = 0; o < 8; o++) begin
        apply(o, 5, 3);
        check("R8", int'(f), ref8[o]);
      end
    end

    // exhaustive sweep: R1 R2 R3 R4 R5 R6; B ignored for some codes (R7)
    for (int o = 0; o < 8; o++) begin
      for (int av = 0; av < NVAL; av++) begin
        for (int bv = 0; bv < NVAL; bv++) begin
          int ef, eu, es, sr;
          string rq;
          eu = 0; es = 0; sr = 0;
          case (o)
            0: begin ef = av;                rq = "R7"; end
            1: begin ef = av & bv;           rq = "R1"; end
            2: begin ef = av | bv;           rq = "R1"; end
            3: begin ef = (~av) & (NVAL-1);  rq = "R7"; end
            4: begin ef = (av + bv) % NVAL; eu = (av + bv >= NVAL); sr = sval(av) + sval(bv); rq = "R2"; end
            5: begin ef = (av - bv + NVAL) % NVAL; eu = (av >= bv); sr = sval(av) - sval(bv); rq = "R2"; end
            6: begin ef = (av + 1) % NVAL; eu = (av == NVAL-1); sr = sval(av) + 1; rq = "R3"; end
            default: begin ef = (av + NVAL - 1) % NVAL; eu = (av != 0); sr = sval(av) - 1; rq = "R3"; end
          endcase
          if (o >= 4) es = (sr < -HALF || sr > HALF-1);
          apply(o, av, bv);
          check(rq, int'(f), ef);
          check((o < 4) ? "R6" : "R4", int'(uovf), eu);
          check((o < 4) ? "R6" : "R5", int'(sovf), es);
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule